// File: doc/BRIEF.md
# AES Round-Parallel Encryption Engine

This block enciphers one 128-bit block at a time with the AES algorithm. It iterates its rounds in place and is not pipelined. Each state byte has its own forward S-box, so the block has sixteen of them. A full round, made of byte substitution, row rotation, column mixing and key addition, completes in one clock. The S-boxes belong to this datapath alone. Key expansion is a separate block, which this engine reads through a combinational port: the engine presents a round index and receives the 128-bit round key for that round in the same cycle.

A client waits for `ready`, then pulses `start` together with the plaintext and the key-length select. In the accepting cycle the engine adds round key 0. It then performs one round per clock. The ciphertext appears on `ct` with a single-cycle `ct_valid` pulse and stays there until the next accepted start.

Top module: `aes_round_engine`

## Requirements
- R1: With `key_len_256` low at acceptance, the engine performs 10 rounds and produces the standard AES-128 ciphertext. Byte k of a 128-bit value occupies bits [127-8k:120-8k]. Byte 4c+r is row r, column c of the state.
- R2: With `key_len_256` high at acceptance, the engine performs 14 rounds and produces the standard AES-256 ciphertext, in the same byte layout.
- R3: `rk_idx` is 0 whenever `ready` is high, including the accepting cycle. During the rounds it reads 1, 2, … up to the round count, rising by one each cycle.
- R4: `ct_valid` rises exactly Nr rising edges after the edge that accepts `start`, where Nr is 10 or 14. One AES-128 block therefore occupies 11 cycles including the start cycle, well inside a 27-cycle budget that also covers key expansion.
- R5: `ct_valid` lasts one cycle. `ct` keeps its value from the completion cycle until the next accepted start.
- R6: `ready` is high when idle and low from the accepting edge until the completion edge. A `start` seen while `ready` is low has no effect on the result or the timing.
- R7: The key length is captured at acceptance. Changing `key_len_256` during a block does not change the round count or the result.
- R8: While reset is asserted (`rst_n` low), `ready` is 1, `ct_valid` is 0 and `rk_idx` is 0.
- R9: The last round leaves out column mixing. The other rounds include it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new block when ready |
| key_len_256 | input | 1 | 1 selects a 256-bit key (14 rounds), 0 selects a 128-bit key (10 rounds) |
| block_in | input | 128 | Plaintext block |
| rk_idx | output | 4 | Index of the round key requested this cycle |
| rk_data | input | 128 | Round key for `rk_idx`, returned in the same cycle |
| ct | output | 128 | Ciphertext, held after completion |
| ready | output | 1 | Engine idle and able to accept a block |
| ct_valid | output | 1 | One-cycle pulse marking a fresh ciphertext |

## Verification
The bench builds the engine with its default round counts, 10 and 14, and a 4-bit round index. At these values the published standard vectors for both key lengths apply directly, and the index port covers every round key of the 256-bit schedule. A behavioural model predicts `ready`, `ct_valid`, `rk_idx` and `ct` for every clock, including back-to-back blocks and starts that arrive while the engine is busy. Random keys of both lengths cover byte values that the standard vectors do not reach.

// File: rtl/aes_round_engine.sv
module aes_round_engine #(
  parameter int ROUNDS_128 = 10,
  parameter int ROUNDS_256 = 14,
  localparam int IW = $clog2(ROUNDS_256 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          key_len_256,
  input  logic [127:0]  block_in,
  output logic [IW-1:0] rk_idx,
  input  logic [127:0]  rk_data,
  output logic [127:0]  ct,
  output logic          ready,
  output logic          ct_valid
);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
    logic [15:0] d;
    d = {v, v} << k;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p, r;
    p = x;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

  logic [127:0]  state, sb, sr, mc, nxt;
  logic [IW-1:0] round;
  logic          busy, long_key, last;

  genvar c, r;
  generate
    for (c = 0; c < 4; c++) begin : g_col
      for (r = 0; r < 4; r++) begin : g_row
        assign sb[127-8*(4*c+r) -: 8] = sbox(state[127-8*(4*c+r) -: 8]);
        assign sr[127-8*(4*c+r) -: 8] = sb[127-8*(4*((c+r)%4)+r) -: 8];
      end
      logic [7:0] a0, a1, a2, a3;
      assign a0 = sr[127-32*c -: 8];
      assign a1 = sr[119-32*c -: 8];
      assign a2 = sr[111-32*c -: 8];
      assign a3 = sr[103-32*c -: 8];
      assign mc[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      assign mc[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      assign mc[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      assign mc[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
  endgenerate

  assign last     = round == IW'(long_key ? ROUNDS_256 : ROUNDS_128);
  assign nxt      = (last ? sr : mc) ^ rk_data;
  assign ready    = !busy;
  assign rk_idx   = round;
  assign ct       = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= '0;
      round    <= '0;
      busy     <= 1'b0;
      long_key <= 1'b0;
      ct_valid <= 1'b0;
    end else begin
      ct_valid <= 1'b0;
      if (busy) begin
        state <= nxt;
        if (last) begin
          busy     <= 1'b0;
          ct_valid <= 1'b1;
          round    <= '0;
        end else begin
          round <= round + 1'b1;
        end
      end else if (start) begin
        state    <= block_in ^ rk_data;
        busy     <= 1'b1;
        round    <= IW'(1);
        long_key <= key_len_256;
      end
    end
  end

endmodule

module aes_round_engine_chk #(
  parameter int ROUNDS_128 = 10,
  parameter int ROUNDS_256 = 14,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic          ct_valid,
  input logic [IW-1:0] rk_idx,
  input logic [127:0]  ct,
  input logic          long_key
);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |=> !ct_valid);

  assert_ct_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && !$past(start)) |-> $stable(ct));

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);

  assert_idle_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> rk_idx == '0);

  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> rk_idx == $past(rk_idx) + 1'b1);

  assert_len_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(long_key));

  assert_done_round_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |-> $past(rk_idx) == IW'(long_key ? ROUNDS_256 : ROUNDS_128));

endmodule

bind aes_round_engine aes_round_engine_chk #(
  .ROUNDS_128(ROUNDS_128), .ROUNDS_256(ROUNDS_256), .IW(IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .ct_valid(ct_valid),
  .rk_idx(rk_idx), .ct(ct), .long_key(long_key)
);

// File: tb/aes_round_engine_tb_top.sv
module aes_round_engine_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         klen = 1'b0;
  logic [127:0] pt = '0;
  logic [3:0]   rk_idx;
  logic [127:0] rk_data, ct;
  logic         ready, ct_valid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aes_round_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len_256(klen),
    .block_in(pt), .rk_idx(rk_idx), .rk_data(rk_data), .ct(ct),
    .ready(ready), .ct_valid(ct_valid)
  );

  logic [127:0] rk_tab [0:15];
  logic [7:0]   sbt [0:255];
  logic [7:0]   ex  [0:255];
  int           lg  [0:255];

  always_comb rk_data = rk_tab[rk_idx];

  function automatic logic [7:0] m2(input logic [7:0] b);
    return (b << 1) ^ ((b & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] inv, s;
    ex[0] = 8'h01;
    for (int i = 1; i < 256; i++) ex[i] = ex[i-1] ^ m2(ex[i-1]);
    for (int i = 0; i < 255; i++) lg[ex[i]] = i;
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      for (int b = 0; b < 8; b++)
        s[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1);
      sbt[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
  endfunction

  task automatic load_key(input logic [255:0] k, input bit lng);
    logic [31:0] w [0:59];
    logic [31:0] t;
    logic [7:0]  rc;
    int nk, tot;
    nk = lng ? 8 : 4;
    tot = lng ? 60 : 44;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) w[i] = k[255-32*i -: 32];
    for (int i = nk; i < tot; i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m2(rc);
      end else if (nk == 8 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int q = 0; q < tot/4; q++) rk_tab[q] = {w[4*q], w[4*q+1], w[4*q+2], w[4*q+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input int nr);
    logic [7:0] st [0:15];
    logic [7:0] tm [0:15];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) st[i] = p[127-8*i -: 8] ^ rk_tab[0][127-8*i -: 8];
    for (int rd = 1; rd <= nr; rd++) begin
      for (int i = 0; i < 16; i++) st[i] = sbt[st[i]];
      for (int cc = 0; cc < 4; cc++)
        for (int rr = 0; rr < 4; rr++) tm[4*cc+rr] = st[4*((cc+rr)%4)+rr];
      for (int cc = 0; cc < 4; cc++) begin
        if (rd < nr) begin
          st[4*cc]   = m2(tm[4*cc]) ^ m2(tm[4*cc+1]) ^ tm[4*cc+1] ^ tm[4*cc+2] ^ tm[4*cc+3];
          st[4*cc+1] = tm[4*cc] ^ m2(tm[4*cc+1]) ^ m2(tm[4*cc+2]) ^ tm[4*cc+2] ^ tm[4*cc+3];
          st[4*cc+2] = tm[4*cc] ^ tm[4*cc+1] ^ m2(tm[4*cc+2]) ^ m2(tm[4*cc+3]) ^ tm[4*cc+3];
          st[4*cc+3] = m2(tm[4*cc]) ^ tm[4*cc] ^ tm[4*cc+1] ^ tm[4*cc+2] ^ m2(tm[4*cc+3]);
        end else begin
          for (int rr = 0; rr < 4; rr++) st[4*cc+rr] = tm[4*cc+rr];
        end
      end
      for (int i = 0; i < 16; i++) st[i] = st[i] ^ rk_tab[rd][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = st[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-level reference model
  int cnt = 0;
  int nr_cur = 10;
  bit m_valid = 0;
  bit m_long = 0;
  logic [127:0] m_ct = '0;
  logic [127:0] m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0;
      m_valid = 0;
    end else begin
      m_valid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          m_valid = 1;
          m_ct = m_pend;
        end
      end else if (start) begin
        nr_cur = klen ? 14 : 10;
        m_long = klen;
        cnt = nr_cur;
        m_pend = ref_enc(pt, nr_cur);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(ready === (cnt == 0), "R6 ready", 128'(ready), 128'(cnt == 0));
      chk(ct_valid === m_valid, "R4/R5 ct_valid", 128'(ct_valid), 128'(m_valid));
      chk(rk_idx === 4'((cnt == 0) ? 0 : nr_cur - cnt + 1), "R3 rk_idx", 128'(rk_idx),
          128'((cnt == 0) ? 0 : nr_cur - cnt + 1));
      if (m_valid) chk(ct === m_ct, m_long ? "R2 ct" : "R1 ct", ct, m_ct);
    end
  end

  task automatic run_block(input logic [127:0] p, input bit lng, output logic [127:0] res, output int lat);
    @(negedge clk);
    pt = p;
    klen = lng;
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!ct_valid && lat < 40);
    res = ct;
  endtask

  logic [127:0] res, ref_v;
  int lat;
  logic [255:0] rkey;

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    chk(ready === 1'b1, "R8 ready in reset", 128'(ready), 128'(1));
    chk(ct_valid === 1'b0, "R8 ct_valid in reset", 128'(ct_valid), 128'(0));
    chk(rk_idx === 4'd0, "R8 rk_idx in reset", 128'(rk_idx), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R9: standard AES-128 vectors
    load_key({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 0);
    run_block(128'h00112233445566778899aabbccddeeff, 0, res, lat);
    chk(res === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 R9 AES-128 vector", res,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(lat == 11, "R4 latency 128", 128'(lat), 128'(11));

    repeat (4) @(negedge clk);
    chk(ct === res, "R5 ct held when idle", ct, res);

    load_key({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 0);
    run_block(128'h3243f6a8885a308d313198a2e0370734, 0, res, lat);
    chk(res === 128'h3925841d02dc09fbdc118597196a0b32, "R1 second AES-128 vector", res,
        128'h3925841d02dc09fbdc118597196a0b32);

    // R2: AES-256 vector
    load_key(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1);
    run_block(128'h00112233445566778899aabbccddeeff, 1, res, lat);
    chk(res === 128'h8ea2b7ca516745bfeafc49904b496089, "R2 AES-256 vector", res,
        128'h8ea2b7ca516745bfeafc49904b496089);
    chk(lat == 15, "R4 latency 256", 128'(lat), 128'(15));

    // R6: start while busy is ignored
    load_key({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 0);
    @(negedge clk);
    pt = 128'h00112233445566778899aabbccddeeff;
    klen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    pt = 128'hdeadbeef0badf00d1234567890abcdef;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!ct_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R6 busy start ignored", ct,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(lat == 11, "R6 busy start timing", 128'(lat), 128'(11));

    // R7: key length changed mid-block
    @(negedge clk);
    pt = 128'h00112233445566778899aabbccddeeff;
    klen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    klen = 1'b1;
    lat = 1;
    while (!ct_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    klen = 1'b0;
    chk(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R7 length held", ct,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(lat == 11, "R7 round count held", 128'(lat), 128'(11));

    // Back-to-back blocks with start held high (model checks each cycle)
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      pt = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    start = 1'b0;
    while (!ready) @(negedge clk);

    // Random keys of both lengths
    for (int i = 0; i < 8; i++) begin
      rkey = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      load_key(rkey, i % 2 == 1);
      pt = {$urandom, $urandom, $urandom, $urandom};
      ref_v = ref_enc(pt, (i % 2 == 1) ? 14 : 10);
      run_block(pt, i % 2 == 1, res, lat);
      chk(res === ref_v, (i % 2 == 1) ? "R2 random block" : "R1 random block", res, ref_v);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule